// File: doc/BRIEF.md
# Bit-Serial Equalizer Divider

This block divides an unsigned sample magnitude by an unsigned channel-gain magnitude. It forms one quotient bit per clock with a single subtractor. The dividend is treated as carrying `FRAC` fractional bits. The result is `floor(dividend * 2^FRAC / divisor)` in `QW` bits, which matches a clock running `QW` times faster than the symbol rate. A start strobe loads the operands. After the last step, the assembled quotient is written to a stable output register and a done flag pulses for one cycle.

When the quotient would not fit in `QW` bits, the result saturates to all ones. A zero divisor also saturates the result and raises an error flag, which stays with that result.

The `DUAL` parameter builds two identical units instead of one. Starts are handed to the two units in turn, so a new division can begin while the other unit is still working. Each unit still takes `QW` cycles per division.

Top module: `serdiv_eq`

## Requirements
- R1: For a divisor B other than 0 and a dividend A, the quotient is floor(A·2^FRAC / B) whenever that value is below 2^QW. With the defaults (12-bit A and B, QW=12, FRAC=10), A=100 and B=200 give 512, and A=B=4095 gives 1024. In that case err is 0.
- R2: If B is not 0 and floor(A·2^FRAC / B) ≥ 2^QW, the quotient is 2^QW−1 and err is 0.
- R3: If B = 0, the quotient is 2^QW−1 and err is 1.
- R4: For a start sampled at clock edge t, the quotient, err and done are updated at edge t+QW and at no earlier edge.
- R5: done is high for exactly one cycle per result. quot_o and err_o change only at the edge that raises done.
- R6: With DUAL=0, a start that arrives while a division is running and is not in its final step is ignored. The running result is unchanged and no extra result appears.
- R7: A start that arrives in the final step of the running division is accepted, so divisions can run back to back every QW cycles.
- R8: Synchronous active-high reset clears quot_o and err_o to 0 and done_o to 0.
- R9: With DUAL=1, accepted starts go to the two units alternately. A start is accepted whenever the unit next in turn is idle or in its final step, and is ignored otherwise. Results appear in start order, each QW cycles after its own start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, sampled at the rising edge |
| dividend_i | input | DW | Unsigned dividend |
| divisor_i | input | VW | Unsigned divisor |
| quot_o | output | QW | Registered quotient |
| done_o | output | 1 | One-cycle pulse when quot_o is updated |
| err_o | output | 1 | Set with a result whose divisor was zero |

## Verification
Two events can fall in the same cycle. One division finishes its final step and loads the output register. A new start loads a unit, which may be the unit that is just finishing. The bench provokes this by issuing starts exactly QW cycles apart, and in the two-unit build by issuing them every cycle. A behavioural model then checks every cycle that the finishing result is intact and that the new start's result arrives QW cycles later. It also issues starts in the middle of a running division and checks that the single-unit build yields no extra result while the two-unit build yields one.

// File: rtl/serdiv_eq_pkg.sv
package serdiv_eq_pkg;
  typedef enum logic {
    LANE_IDLE = 1'b0,
    LANE_RUN  = 1'b1
  } lane_st_e;
endpackage

// File: rtl/serdiv_step.sv
// One restoring step: append the next dividend bit, trial-subtract the divisor,
// keep the difference when it is non-negative.
module serdiv_step #(
  parameter int VW = 12
) (
  input  logic [VW-1:0] rem_i,
  input  logic          bit_i,
  input  logic [VW-1:0] dvs_i,
  output logic [VW-1:0] rem_o,
  output logic          q_o
);
  localparam int TW = VW + 1;

  logic [TW-1:0] trial;
  logic [TW:0]   diff;

  always_comb begin
    trial = {rem_i, bit_i};
    diff  = {1'b0, trial} - {2'b00, dvs_i};
    q_o   = ~diff[TW];
    rem_o = diff[TW] ? trial[VW-1:0] : diff[VW-1:0];
  end
endmodule

// File: rtl/serdiv_sipo.sv
// Serial-to-parallel collector for quotient bits, MSB first.
module serdiv_sipo #(
  parameter int QW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift_en,
  input  logic          bit_i,
  output logic [QW-1:0] par_o
);
  always_ff @(posedge clk) begin
    if (rst)
      par_o <= '0;
    else if (shift_en)
      par_o <= {par_o[QW-2:0], bit_i};
  end
endmodule

// File: rtl/serdiv_lane.sv
module serdiv_lane
  import serdiv_eq_pkg::*;
#(
  parameter int DW   = 12,
  parameter int VW   = 12,
  parameter int QW   = 12,
  parameter int FRAC = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic          rdy,
  output logic          fin,
  output logic [QW-1:0] q_fin,
  output logic          err_fin
);
  localparam int NW   = DW + FRAC;
  localparam int HW   = NW - QW;
  localparam int CW   = (HW > VW) ? HW : VW;
  localparam int CNTW = (QW > 1) ? $clog2(QW) : 1;
  localparam logic [CNTW-1:0] LAST = CNTW'(QW - 1);

  lane_st_e        st;
  logic [CNTW-1:0] cnt;
  logic [VW-1:0]   rem;
  logic [QW-1:0]   feed;
  logic [VW-1:0]   dvs;
  logic            ovf;
  logic            zero;

  logic [NW-1:0]   num;
  logic [CW-1:0]   hi_c;
  logic [CW-1:0]   dv_c;
  logic            ovf_in;
  logic [VW-1:0]   rem_nxt;
  logic            qbit;
  logic [QW-1:0]   par;
  logic            running;
  logic            last;

  always_comb begin
    num    = {dividend, {FRAC{1'b0}}};
    hi_c   = CW'(num[NW-1:QW]);
    dv_c   = CW'(divisor);
    ovf_in = (hi_c >= dv_c);
  end

  assign running = (st == LANE_RUN);
  assign last    = running && (cnt == LAST);
  assign rdy     = !running || last;
  assign fin     = last;

  serdiv_step #(.VW(VW)) u_step (
    .rem_i (rem),
    .bit_i (feed[QW-1]),
    .dvs_i (dvs),
    .rem_o (rem_nxt),
    .q_o   (qbit)
  );

  serdiv_sipo #(.QW(QW)) u_sipo (
    .clk      (clk),
    .rst      (rst),
    .shift_en (running),
    .bit_i    (qbit),
    .par_o    (par)
  );

  always_comb begin
    q_fin   = ovf ? {QW{1'b1}} : {par[QW-2:0], qbit};
    err_fin = zero;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= LANE_IDLE;
      cnt  <= '0;
      rem  <= '0;
      feed <= '0;
      dvs  <= '0;
      ovf  <= 1'b0;
      zero <= 1'b0;
    end else if (load) begin
      st   <= LANE_RUN;
      cnt  <= '0;
      rem  <= VW'(hi_c);
      feed <= num[QW-1:0];
      dvs  <= divisor;
      ovf  <= ovf_in;
      zero <= (divisor == '0);
    end else if (running) begin
      rem  <= rem_nxt;
      feed <= {feed[QW-2:0], 1'b0};
      cnt  <= cnt + 1'b1;
      if (last)
        st <= LANE_IDLE;
    end
  end
endmodule

// File: rtl/serdiv_eq.sv
module serdiv_eq #(
  parameter int DW   = 12,
  parameter int VW   = 12,
  parameter int QW   = 12,
  parameter int FRAC = 10,
  parameter bit DUAL = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [VW-1:0] divisor_i,
  output logic [QW-1:0] quot_o,
  output logic          done_o,
  output logic          err_o
);
  localparam int LANES = DUAL ? 2 : 1;

  logic [LANES-1:0] lane_rdy;
  logic [LANES-1:0] lane_fin;
  logic [LANES-1:0] lane_load;
  logic [QW-1:0]    lane_q   [LANES];
  logic [LANES-1:0] lane_err;
  logic             ptr;
  logic             tgt_rdy;
  logic             accept;

  generate
    if (LANES == 2) begin : g_pp
      assign tgt_rdy   = ptr ? lane_rdy[1] : lane_rdy[0];
      assign accept    = start_i && tgt_rdy;
      assign lane_load = {accept && ptr, accept && !ptr};
      always_ff @(posedge clk) begin
        if (rst)
          ptr <= 1'b0;
        else if (accept)
          ptr <= ~ptr;
      end
    end else begin : g_single
      assign tgt_rdy   = lane_rdy[0];
      assign accept    = start_i && tgt_rdy;
      assign lane_load = accept;
      assign ptr       = 1'b0;
    end
  endgenerate

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      serdiv_lane #(.DW(DW), .VW(VW), .QW(QW), .FRAC(FRAC)) u_lane (
        .clk      (clk),
        .rst      (rst),
        .load     (lane_load[g]),
        .dividend (dividend_i),
        .divisor  (divisor_i),
        .rdy      (lane_rdy[g]),
        .fin      (lane_fin[g]),
        .q_fin    (lane_q[g]),
        .err_fin  (lane_err[g])
      );
    end
  endgenerate

  logic [QW-1:0] sel_q;
  logic          sel_err;

  always_comb begin
    sel_q   = '0;
    sel_err = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (lane_fin[i]) begin
        sel_q   = lane_q[i];
        sel_err = lane_err[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      quot_o <= '0;
      err_o  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= |lane_fin;
      if (|lane_fin) begin
        quot_o <= sel_q;
        err_o  <= sel_err;
      end
    end
  end
endmodule

// File: rtl/serdiv_eq_chk.sv
module serdiv_eq_chk #(
  parameter int QW    = 12,
  parameter int LANES = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic [QW-1:0]    quot_o,
  input logic             done_o,
  input logic             err_o,
  input logic [LANES-1:0] lane_fin,
  input logic             tgt_rdy,
  input logic             ptr
);
  a_r3_zero_saturates: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (quot_o == {QW{1'b1}}));

  a_r5_output_holds: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(quot_o) && $stable(err_o)));

  a_r9_single_finisher: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lane_fin));

  a_r6_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (start_i && !tgt_rdy) |=> $stable(ptr));

  generate
    if (LANES == 2) begin : g_pp_chk
      a_r9_alternate: assert property (@(posedge clk) disable iff (rst)
        (start_i && tgt_rdy) |=> (ptr != $past(ptr)));
    end
  endgenerate
endmodule

bind serdiv_eq serdiv_eq_chk #(.QW(QW), .LANES(LANES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start_i  (start_i),
  .quot_o   (quot_o),
  .done_o   (done_o),
  .err_o    (err_o),
  .lane_fin (lane_fin),
  .tgt_rdy  (tgt_rdy),
  .ptr      (ptr)
);

// File: tb/serdiv_eq_test.sv
// Behavioural reference: per-unit countdown of edges left and the stored result.
module serdiv_eq_model #(
  parameter int LANES = 1,
  parameter int DW    = 12,
  parameter int VW    = 12,
  parameter int QW    = 12,
  parameter int FRAC  = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] a,
  input  logic [VW-1:0] b,
  output logic [QW-1:0] q,
  output logic          done,
  output logic          err
);
  int            left [LANES];
  logic [QW-1:0] res  [LANES];
  logic          rerr [LANES];
  int            ptr;

  function automatic logic [QW:0] expect_of(longint unsigned av, longint unsigned bv);
    longint unsigned n;
    longint unsigned mx;
    longint unsigned v;
    n  = av << FRAC;
    mx = (64'd1 << QW) - 1;
    if (bv == 0) return {1'b1, QW'(mx)};
    v = n / bv;
    if (v > mx) v = mx;
    return {1'b0, QW'(v)};
  endfunction

  always @(posedge clk) begin
    logic          f;
    logic [QW:0]   e;
    if (rst) begin
      for (int l = 0; l < LANES; l++) begin
        left[l] = 0;
        res[l]  = '0;
        rerr[l] = 1'b0;
      end
      ptr  = 0;
      q    <= '0;
      err  <= 1'b0;
      done <= 1'b0;
    end else begin
      f = 1'b0;
      for (int l = 0; l < LANES; l++) begin
        if (left[l] == 1) begin
          q   <= res[l];
          err <= rerr[l];
          f   = 1'b1;
        end
        if (left[l] > 0) left[l] = left[l] - 1;
      end
      if (start && left[ptr] == 0) begin
        e         = expect_of(a, b);
        left[ptr] = QW;
        res[ptr]  = e[QW-1:0];
        rerr[ptr] = e[QW];
        ptr       = (ptr + 1) % LANES;
      end
      done <= f;
    end
  end
endmodule

module serdiv_eq_test;
  localparam int DW = 12, VW = 12, QW = 12, FRAC = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [DW-1:0] a = '0;
  logic [VW-1:0] b = '0;

  logic [QW-1:0] q_s, q_d, mq_s, mq_d;
  logic          dn_s, dn_d, mdn_s, mdn_d;
  logic          er_s, er_d, mer_s, mer_d;

  int    total = 0;
  int    bad   = 0;
  bit    ended = 1'b0;
  string tag   = "R8";

  always #10 clk = ~clk;

  serdiv_eq #(.DW(DW), .VW(VW), .QW(QW), .FRAC(FRAC), .DUAL(1'b0)) uut (
    .clk(clk), .rst(rst), .start_i(start), .dividend_i(a), .divisor_i(b),
    .quot_o(q_s), .done_o(dn_s), .err_o(er_s));

  serdiv_eq #(.DW(DW), .VW(VW), .QW(QW), .FRAC(FRAC), .DUAL(1'b1)) uut_pp (
    .clk(clk), .rst(rst), .start_i(start), .dividend_i(a), .divisor_i(b),
    .quot_o(q_d), .done_o(dn_d), .err_o(er_d));

  serdiv_eq_model #(.LANES(1), .DW(DW), .VW(VW), .QW(QW), .FRAC(FRAC)) ref_s (
    .clk(clk), .rst(rst), .start(start), .a(a), .b(b),
    .q(mq_s), .done(mdn_s), .err(mer_s));

  serdiv_eq_model #(.LANES(2), .DW(DW), .VW(VW), .QW(QW), .FRAC(FRAC)) ref_d (
    .clk(clk), .rst(rst), .start(start), .a(a), .b(b),
    .q(mq_d), .done(mdn_d), .err(mer_d));

  task automatic check(string req, logic [QW+1:0] act, logic [QW+1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got {q,done,err}=%h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Every cycle: both builds against their reference models.
  always @(negedge clk) begin
    if (!rst && !ended) begin
      check(tag, {q_s, dn_s, er_s}, {mq_s, mdn_s, mer_s});
      check({"R9/", tag}, {q_d, dn_d, er_d}, {mq_d, mdn_d, mer_d});
    end
  end

  task automatic issue(logic [DW-1:0] av, logic [VW-1:0] bv, int gap);
    a = av; b = bv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (gap - 1) @(negedge clk);
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got running expected finished");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: outputs cleared by reset
    check("R8", {q_s, dn_s, er_s}, '0);
    check("R8", {q_d, dn_d, er_d}, '0);

    // R4: done rises after edge t+QW, not after t+QW-1
    tag = "R4";
    a = 12'd100; b = 12'd200; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (QW - 1) @(negedge clk);
    check("R4", {{QW{1'b0}}, dn_s, 1'b0}, '0);
    @(negedge clk);
    check("R4", {q_s, dn_s, er_s}, {12'd512, 1'b1, 1'b0});
    repeat (4) @(negedge clk);

    // R1: exact quotients
    tag = "R1";
    issue(12'd4095, 12'd4095, 16);
    issue(12'd1, 12'd4095, 16);
    issue(12'd3, 12'd7, 16);
    issue(12'd2047, 12'd1024, 16);
    // R2: overflow saturates, no error
    tag = "R2";
    issue(12'd4095, 12'd1, 16);
    issue(12'd4095, 12'd2, 16);
    issue(12'd4095, 12'd1023, 16);
    // R3: zero divisor
    tag = "R3";
    issue(12'd500, 12'd0, 16);
    issue(12'd0, 12'd0, 16);
    // R6: start mid-division (ignored by single build, taken by second unit)
    tag = "R6";
    issue(12'd1000, 12'd300, 4);
    issue(12'd7, 12'd9, 20);
    // R7: back-to-back starts exactly QW apart
    tag = "R7";
    issue(12'd10, 12'd3, QW);
    issue(12'd4000, 12'd4001, QW);
    issue(12'd9, 12'd0, QW);
    issue(12'd77, 12'd5, 20);
    // R9/R5: start every cycle, then every half period
    tag = "R5";
    for (int i = 0; i < 40; i++) issue(DW'($urandom), VW'($urandom), 1);
    for (int i = 0; i < 40; i++) issue(DW'($urandom), VW'($urandom), QW / 2);
    // R1/R2/R3 random stream
    tag = "R1";
    for (int i = 0; i < 3000; i++) begin
      logic [VW-1:0] bv;
      bv = ($urandom % 8 == 0) ? '0 : VW'($urandom >> ($urandom % 10));
      if ($urandom % 3 == 0) issue(DW'($urandom), bv, 1);
      else @(negedge clk);
    end
    repeat (30) @(negedge clk);
    finish_up();
  end
endmodule